// File: doc/BRIEF.md
# Word-Serial SPI Master With Register Access

This block is an SPI master driven through a small 16-bit register window. It has three registers: one that moves a data word, one for control and one for status. Software fills in the control register to pick the word size (8 or 16 bits), the clock polarity and phase, and a 7-bit rate divider. It then writes a word to the data register. The block shifts that word out on MOSI, most significant bit first, and at the same time captures a word from MISO. When the word is done it raises a receive-full flag and holds the received word until software reads it.

Chip selects are driven elsewhere, by general-purpose outputs. A transfer that only receives is started by writing a zero word. A single interrupt line combines two conditions, each with its own enable: a received word is waiting, or the engine is idle and ready to take another write. Clearing the enable bit stops the engine at once.

Top module: `spi_word_master`

## Requirements
- R1: After reset the control and status registers read as zero, `sclk` is low and `irq` is low.
- R2: The register byte addresses are 0 for data, 2 for control and 4 for status. Control keeps bits 0 (enable), 2 (16-bit words), 5 (receive interrupt enable), 6 (ready interrupt enable), 7 (idle clock high), 8 (sample on trailing edge) and 15:9 (divider N). All other control bits read as zero. Writes to the status register are ignored.
- R3: In 8-bit mode the byte in data bits 7:0 is sent MSB first. The received byte reads back in bits 7:0, and bits 15:8 read as zero.
- R4: In 16-bit mode data bit 15 goes out first. The first bit received lands in bit 15 of the received word.
- R5: `sclk` rests at the level of control bit 7. With bit 8 clear, data is sampled on the leading edge. With bit 8 set, data is sampled on the trailing edge. All four combinations carry data correctly.
- R6: Each half period of `sclk` lasts N+1 clock cycles. The first and last `sclk` edges of a W-bit word are (2W-1)(N+1) cycles apart.
- R7: Status bit 0 is busy and status bit 1 is receive-full. Reading the data register clears receive-full.
- R8: A data write starts a transfer only while the block is enabled and not busy. Otherwise the write is ignored.
- R9: Clearing the enable bit aborts a transfer in progress. Busy and receive-full clear, and `sclk` returns to its idle level.
- R10: `irq` = (receive-full AND bit 5) OR (not busy AND enabled AND bit 6).
- R11: With `byte_acc` high, a write uses only `wdata[7:0]`: data becomes {8'h00, byte}, and control changes only in bits 7:0. A data read with `byte_acc` high returns the received word with bits 15:8 forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register byte address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (data reads consume the word) |
| byte_acc | input | 1 | Access is 8 bits wide |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong edge index or phase state shows up as a corrupted bit in the captured word. It is seen at the latest when that word is read back, one word time after the fault. A divider count that is off changes the time between the first and last `sclk` edge in the very word where it occurs. A receive-full or busy flag that is stale shows up on `irq` and in the status register within one cycle, because both are derived combinationally from those flags.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int DIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        byte_acc,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam logic [15:0] CTL_MASK = 16'hFFE5;
  localparam int          EDGE_W   = 5;

  logic [15:0] ctl, txsr, rxsr, rxbuf;
  logic        busy, rxfull, phase;
  logic [DIV_W-1:0]  cnt;
  logic [EDGE_W-1:0] edge_n;

  wire en    = ctl[0];
  wire wide  = ctl[2];
  wire rxie  = ctl[5];
  wire rdyie = ctl[6];
  wire cpol  = ctl[7];
  wire cpha  = ctl[8];
  wire [DIV_W-1:0] div = ctl[9 +: DIV_W];

  wire hit_data = addr == 3'd0;
  wire hit_ctl  = addr == 3'd2;
  wire hit_stat = addr == 3'd4;

  wire        start     = wr_en && hit_data && en && !busy;
  wire        tick      = busy && cnt == div;
  wire        last_edge = edge_n == (wide ? 5'd31 : 5'd15);
  wire        lead      = ~edge_n[0];
  wire        samp      = tick && (lead ^ cpha);
  wire        shft      = tick && !samp && !(cpha && edge_n == '0);
  wire        done      = tick && last_edge;
  wire [15:0] rx_next   = {rxsr[14:0], miso};
  wire [15:0] rx_fin    = samp ? rx_next : rxsr;
  wire [15:0] load_word = byte_acc ? {8'h00, wdata[7:0]} : wdata;

  assign sclk = cpol ^ phase;
  assign mosi = txsr[15];
  assign irq  = (rxfull && rxie) || (!busy && en && rdyie);

  always_comb begin
    rdata = '0;
    if (hit_data)      rdata = byte_acc ? {8'h00, rxbuf[7:0]} : rxbuf;
    else if (hit_ctl)  rdata = ctl;
    else if (hit_stat) rdata = {14'b0, rxfull, busy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      txsr   <= '0;
      rxsr   <= '0;
      rxbuf  <= '0;
      busy   <= 1'b0;
      rxfull <= 1'b0;
      phase  <= 1'b0;
      cnt    <= '0;
      edge_n <= '0;
    end else begin
      if (wr_en && hit_ctl)
        ctl <= byte_acc ? {ctl[15:8], wdata[7:0] & CTL_MASK[7:0]} : (wdata & CTL_MASK);
      if (!en) begin
        busy   <= 1'b0;
        rxfull <= 1'b0;
        phase  <= 1'b0;
        cnt    <= '0;
        edge_n <= '0;
      end else begin
        if (rd_en && hit_data) rxfull <= 1'b0;
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          edge_n <= '0;
          phase  <= 1'b0;
          txsr   <= wide ? load_word : {load_word[7:0], 8'h00};
        end else if (tick) begin
          cnt    <= '0;
          phase  <= ~phase;
          edge_n <= edge_n + 1'b1;
          if (samp) rxsr <= rx_next;
          if (shft) txsr <= {txsr[14:0], 1'b0};
          if (last_edge) begin
            busy   <= 1'b0;
            rxfull <= 1'b1;
            rxbuf  <= wide ? rx_fin : {8'h00, rx_fin[7:0]};
          end
        end else if (busy) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctl,
  input logic        busy,
  input logic        rxfull,
  input logic        done,
  input logic        sclk,
  input logic        irq,
  input logic        rd_en,
  input logic [2:0]  addr
);
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[0]) |=> (!busy && !rxfull));

  assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == ctl[7]);

  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sclk == ctl[7]);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0 && !done) |=> !rxfull);

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[0] |=> !busy);

  assert_irq_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rxfull && ctl[5]) |-> irq);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(rxfull && ctl[5])) |-> !irq);
endmodule

bind spi_word_master spi_word_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .busy(busy), .rxfull(rxfull),
  .done(done), .sclk(sclk), .irq(irq), .rd_en(rd_en), .addr(addr)
);

// File: tb/spi_word_master_tb_top.sv
module spi_word_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, byte_acc = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, sclk, mosi, miso;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_word_master dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .byte_acc(byte_acc), .wdata(wdata), .rdata(rdata), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  logic [15:0] s_tx = '0, s_rx = '0;
  logic        s_cpol = 1'b0, s_cpha = 1'b0, s_active = 1'b0, s_wide = 1'b0;
  int          s_cnt = 0, s_total = 16;
  assign miso = s_tx[15];

  always @(sclk) begin
    if (s_active && s_cnt < s_total) begin
      if ((sclk != s_cpol) ^ s_cpha) s_rx = {s_rx[14:0], mosi};
      else if (!(s_cpha && s_cnt == 0)) s_tx = {s_tx[14:0], 1'b0};
      s_cnt = s_cnt + 1;
    end
  end

  int q_mosi[$];
  int q_len[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int t_now = 0, t_first = 0;
  always @(negedge clk) begin
    t_now++;
    if (s_active) begin
      if (s_cnt == 1 && t_first == 0) t_first = t_now;
      if (s_cnt == s_total && q_mosi.size() > 0) begin
        int em, el, got;
        em = q_mosi.pop_front();
        el = q_len.pop_front();
        got = s_wide ? int'(s_rx) : int'(s_rx[7:0]);
        check(got == em, "R3/R4 mosi word", got, em);
        check(t_now - t_first == el, "R6 edge span", t_now - t_first, el);
        s_active = 1'b0;
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d, input bit b);
    @(negedge clk);
    addr = a; wdata = d; byte_acc = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; byte_acc = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input bit b, output logic [15:0] d);
    @(negedge clk);
    addr = a; byte_acc = b; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; byte_acc = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    st = 16'h1;
    while (st[0]) bus_rd(3'd4, 1'b0, st);
  endtask

  task automatic xfer(input logic [15:0] w, input logic [15:0] sw, input bit wide,
                      input int n, input bit poke, input bit bytew, input string req);
    logic [15:0] txw, exp_rx, got;
    int bits;
    bits = wide ? 16 : 8;
    txw = bytew ? {8'h00, w[7:0]} : w;
    s_tx = wide ? sw : {sw[7:0], 8'h00};
    s_rx = '0; s_cnt = 0; s_total = 2 * bits; s_wide = wide; t_first = 0;
    s_active = 1'b1;
    q_mosi.push_back(wide ? int'(txw) : int'(txw[7:0]));
    q_len.push_back((2 * bits - 1) * (n + 1));
    bus_wr(3'd0, w, bytew);
    if (poke) begin
      repeat (3) @(negedge clk);
      bus_wr(3'd0, 16'hFFFF, 1'b0);
    end
    wait_idle();
    exp_rx = wide ? sw : {8'h00, sw[7:0]};
    bus_rd(3'd0, 1'b0, got);
    check(got == exp_rx, req, got, exp_rx);
  endtask

  function automatic logic [15:0] mk_ctl(bit en, bit wide, bit rxie, bit rdyie,
                                         bit cpol, bit cpha, int n);
    return {n[6:0], cpha, cpol, rdyie, rxie, 2'b00, wide, 1'b0, en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_rd(3'd2, 1'b0, v); check(v == 16'h0, "R1 ctl reset", v, 0);
    bus_rd(3'd4, 1'b0, v); check(v == 16'h0, "R1 status reset", v, 0);
    check(sclk == 1'b0, "R1 sclk reset", sclk, 0);
    check(irq == 1'b0, "R1 irq reset", irq, 0);

    bus_wr(3'd2, 16'hFFFF, 1'b0);
    bus_rd(3'd2, 1'b0, v); check(v == 16'hFFE5, "R2 ctl mask", v, 16'hFFE5);
    bus_wr(3'd2, 16'h0000, 1'b0);
    bus_wr(3'd4, 16'hFFFF, 1'b0);
    bus_rd(3'd4, 1'b0, v); check(v == 16'h0, "R2 status write ignored", v, 0);

    s_cpol = 0; s_cpha = 0;
    bus_wr(3'd2, mk_ctl(1, 0, 0, 0, 0, 0, 1), 1'b0);
    xfer(16'h77A5, 16'h993C, 1'b0, 1, 1'b0, 1'b0, "R3 8-bit rx");

    for (int m = 0; m < 4; m++) begin
      s_cpol = m[1]; s_cpha = m[0];
      bus_wr(3'd2, mk_ctl(1, 1, 0, 0, m[1], m[0], m), 1'b0);
      check(sclk == m[1], "R5 idle level", sclk, m[1]);
      xfer(16'hC3A1 ^ 16'(m), 16'h5E72 + 16'(m), 1'b1, m, 1'b0, 1'b0, "R4 R5 16-bit rx");
    end

    s_cpol = 1; s_cpha = 1;
    bus_wr(3'd2, mk_ctl(1, 0, 0, 0, 1, 1, 2), 1'b0);
    xfer(16'h0081, 16'h00C6, 1'b0, 2, 1'b0, 1'b0, "R5 8-bit mode3 rx");

    s_cpol = 0; s_cpha = 1;
    bus_wr(3'd2, mk_ctl(1, 1, 0, 0, 0, 1, 0), 1'b0);
    xfer(16'h1234, 16'hBEEF, 1'b1, 0, 1'b1, 1'b0, "R8 write while busy");
    s_tx = 16'hA000; s_active = 1'b1; s_cnt = 0; s_total = 32; t_first = 0;
    q_mosi.push_back(16'h6E5D); q_len.push_back(31);
    bus_wr(3'd0, 16'h6E5D, 1'b0);
    wait_idle();
    bus_rd(3'd4, 1'b0, v); check(v[1] == 1'b1, "R7 rxfull set", v, 2);
    bus_rd(3'd0, 1'b0, v); check(v == 16'hA000, "R4 rx word", v, 16'hA000);
    bus_rd(3'd4, 1'b0, v); check(v[1] == 1'b0, "R7 rxfull cleared", v, 0);

    bus_wr(3'd2, mk_ctl(0, 1, 0, 0, 0, 0, 1), 1'b0);
    bus_wr(3'd0, 16'h5555, 1'b0);
    bus_rd(3'd4, 1'b0, v); check(v == 16'h0, "R8 disabled write ignored", v, 0);
    check(sclk == 1'b0, "R8 no clock when disabled", sclk, 0);

    bus_wr(3'd2, mk_ctl(1, 1, 0, 0, 1, 0, 20), 1'b0);
    bus_wr(3'd0, 16'hF0F0, 1'b0);
    repeat (30) @(negedge clk);
    bus_rd(3'd4, 1'b0, v); check(v[0] == 1'b1, "R9 busy before abort", v, 1);
    bus_wr(3'd2, mk_ctl(0, 1, 0, 0, 1, 0, 20), 1'b0);
    @(negedge clk);
    bus_rd(3'd4, 1'b0, v); check(v == 16'h0, "R9 abort clears flags", v, 0);
    check(sclk == 1'b1, "R9 sclk idle after abort", sclk, 1);

    bus_wr(3'd2, mk_ctl(0, 0, 0, 1, 0, 0, 1), 1'b0);
    @(negedge clk); check(irq == 1'b0, "R10 ready irq needs enable", irq, 0);
    s_cpol = 0; s_cpha = 0;
    bus_wr(3'd2, mk_ctl(1, 0, 1, 1, 0, 0, 1), 1'b0);
    @(negedge clk); check(irq == 1'b1, "R10 ready irq", irq, 1);
    s_tx = 16'h4200; s_rx = '0; s_cnt = 0; s_total = 16; s_wide = 0; t_first = 0;
    s_active = 1'b1;
    q_mosi.push_back(16'h0011); q_len.push_back(30);
    bus_wr(3'd0, 16'h0011, 1'b0);
    @(negedge clk); check(irq == 1'b0, "R10 irq low while busy", irq, 0);
    wait_idle();
    bus_wr(3'd2, mk_ctl(1, 0, 1, 0, 0, 0, 1), 1'b0);
    @(negedge clk); check(irq == 1'b1, "R10 rx irq", irq, 1);
    bus_rd(3'd0, 1'b0, v); check(v == 16'h0042, "R3 rx byte", v, 16'h0042);
    @(negedge clk); check(irq == 1'b0, "R10 irq drops after read", irq, 0);

    bus_wr(3'd2, mk_ctl(1, 1, 0, 0, 0, 0, 3), 1'b0);
    bus_wr(3'd2, 16'h0005, 1'b1);
    bus_rd(3'd2, 1'b0, v);
    check(v == 16'h0605, "R11 byte ctl write", v, 16'h0605);
    s_cpol = 0; s_cpha = 0;
    xfer(16'hABCD, 16'h1357, 1'b1, 3, 1'b0, 1'b1, "R11 byte data write");
    s_tx = 16'h9A7B; s_rx = '0; s_cnt = 0; s_total = 32; s_wide = 1; t_first = 0;
    s_active = 1'b1;
    q_mosi.push_back(16'h0000); q_len.push_back(31 * 4);
    bus_wr(3'd0, 16'h0000, 1'b0);
    wait_idle();
    bus_rd(3'd0, 1'b1, v); check(v == 16'h007B, "R11 byte data read", v, 16'h007B);

    repeat (5) @(negedge clk);
    check(q_mosi.size() == 0, "R6 all words seen", q_mosi.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule